// File: doc/BRIEF.md
# Frame-Relative Channel Waveform Generator

This block turns a shared frame counter into a bank of independent pulse outputs. Each output channel holds two programmed offsets. When the counter reaches the set offset, the channel's internal level goes active. When the counter reaches the clear offset, the level goes inactive. Between the two hits the level holds. Because both offsets are measured from frame count zero, every channel is timed relative to the start of the frame. A channel whose set offset lies above its clear offset stays active across the frame boundary.

The offsets are compared only while the surrounding controller reports that it is running. A per-channel enable request gates each channel. That request takes effect only while the controller is armed or on an end-of-frame strobe, so a channel is never switched on or off halfway through a frame. A per-channel polarity bit inverts what the pin shows. An idle or disabled channel therefore drives its polarity level.

The bank is parameterised in channel count and counter width. Bit i of every per-channel vector, and field i of every packed offset bus, belongs to channel i. The frame counter, the register interface and sync handling live outside this block.

Top module: `fpg_bank`

## Requirements
- R1: While running_i is 1 and the channel's latched enable is 1, a clock edge at which cnt_i equals the channel's set offset (and not its clear offset) makes the channel active; ch_o shows this after that same edge (one register of latency).
- R2: While running_i is 1 and the channel's latched enable is 1, a clock edge at which cnt_i equals the channel's clear offset makes the channel inactive after that edge.
- R3: At a clock edge where running_i is 0, every channel goes inactive and no offset compare takes effect; after the edge each pin shows its polarity bit.
- R4: The latched enable vector takes the value of en_req_i at an edge where armed_i or frame_end_i is 1; at any other edge a change of en_req_i has no effect on the latched enables or on the pins.
- R5: When the set and clear offsets are equal, a compare hit leaves the channel inactive (the clear compare wins).
- R6: The pin is the active level (1 for active, 0 for inactive) XOR the channel's polarity bit, as sampled at the same edge that updates the level.
- R7: A channel whose latched enable is 0 is held inactive, so its pin shows only its polarity bit.
- R8: Bit i of en_req_i, pol_i and ch_o, and bits [i*W +: W] of on_ofs_i and off_ofs_i, belong to channel i (the LSB and field 0 belong to channel 0).
- R9: While rst_n is 0 at a clock edge (synchronous, active low), every pin and every latched enable is cleared to 0.
- R10: While running and enabled, at an edge where cnt_i matches neither offset, the channel keeps its previous active or inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | W | Shared frame-relative counter value |
| running_i | input | 1 | Controller is running; offset compares are live |
| armed_i | input | 1 | Controller is armed; enable requests are taken |
| frame_end_i | input | 1 | Last cycle of a frame; enable requests are taken |
| on_ofs_i | input | NUM_CH*W | Packed set offsets, field i for channel i |
| off_ofs_i | input | NUM_CH*W | Packed clear offsets, field i for channel i |
| en_req_i | input | NUM_CH | Requested channel enables |
| pol_i | input | NUM_CH | Channel polarity bits (1 inverts) |
| ch_o | output | NUM_CH | Registered channel pins |

## Verification
The bench builds the bank with four channels and an 8-bit counter, so short frames of ten to twelve counts reach many frame boundaries. In these frames every channel's offsets can sit inside, on the edge of, or beyond the frame. With four channels, the bench gives each channel a different offset shape in the same frame: an ordinary pulse, one that wraps across the boundary, equal set and clear offsets, and an inverted one. This shows that packed fields do not bleed into each other. The narrow width also lets random offsets collide with the counter often, so set, clear and hold cases all occur densely while enable requests arrive both mid-frame and on boundaries.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_SET  = 2'd1,
        HIT_CLR  = 2'd2
    } fpg_hit_e;

    typedef struct packed {
        logic act;
        logic pin;
    } fpg_chan_t;

endpackage

// File: rtl/fpg_cmp.sv
module fpg_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0]      cnt_i,
    input  logic [W-1:0]      set_i,
    input  logic [W-1:0]      clr_i,
    output fpg_pkg::fpg_hit_e hit_o
);
    import fpg_pkg::*;

    // Clear compare has priority over set compare
    always_comb begin
        if (cnt_i == clr_i) begin
            hit_o = HIT_CLR;
        end else if (cnt_i == set_i) begin
            hit_o = HIT_SET;
        end else begin
            hit_o = HIT_NONE;
        end
    end

endmodule

// File: rtl/fpg_enable_gate.sv
module fpg_enable_gate #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed_i,
    input  logic              frame_end_i,
    input  logic [NUM_CH-1:0] en_req_i,
    output logic [NUM_CH-1:0] en_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (armed_i || frame_end_i) begin
            gate_d.en = en_req_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign en_o = gate_q.en;

endmodule

// File: rtl/fpg_channel.sv
module fpg_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         run_i,
    input  logic         en_i,
    input  logic         pol_i,
    output logic         pin_o
);
    import fpg_pkg::*;

    fpg_hit_e  hit;
    fpg_chan_t st_d, st_q;

    fpg_cmp #(.W(W)) cmp_i (
        .cnt_i (cnt_i),
        .set_i (set_i),
        .clr_i (clr_i),
        .hit_o (hit)
    );

    always_comb begin
        st_d = st_q;
        if (!run_i || !en_i) begin
            st_d.act = 1'b0;
        end else begin
            case (hit)
                HIT_CLR: st_d.act = 1'b0;
                HIT_SET: st_d.act = 1'b1;
                default: st_d.act = st_q.act;
            endcase
        end
        st_d.pin = st_d.act ^ pol_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;

endmodule

// File: rtl/fpg_bank.sv
module fpg_bank #(
    parameter int NUM_CH = 8,
    parameter int W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        cnt_i,
    input  logic                running_i,
    input  logic                armed_i,
    input  logic                frame_end_i,
    input  logic [NUM_CH*W-1:0] on_ofs_i,
    input  logic [NUM_CH*W-1:0] off_ofs_i,
    input  logic [NUM_CH-1:0]   en_req_i,
    input  logic [NUM_CH-1:0]   pol_i,
    output logic [NUM_CH-1:0]   ch_o
);

    localparam int BUS_W = NUM_CH * W;

    logic [NUM_CH-1:0] en_lat;
    logic [BUS_W-1:0]  on_bus;
    logic [BUS_W-1:0]  off_bus;

    assign on_bus  = on_ofs_i;
    assign off_bus = off_ofs_i;

    fpg_enable_gate #(.NUM_CH(NUM_CH)) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed_i     (armed_i),
        .frame_end_i (frame_end_i),
        .en_req_i    (en_req_i),
        .en_o        (en_lat)
    );

    // Channel i takes field i of each offset bus (R8)
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        fpg_channel #(.W(W)) ch_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i (cnt_i),
            .set_i (on_bus[i*W +: W]),
            .clr_i (off_bus[i*W +: W]),
            .run_i (running_i),
            .en_i  (en_lat[i]),
            .pol_i (pol_i[i]),
            .pin_o (ch_o[i])
        );
    end

endmodule

// File: rtl/fpg_bank_chk.sv
module fpg_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int W      = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [W-1:0]        cnt_i,
    input logic                running_i,
    input logic                armed_i,
    input logic                frame_end_i,
    input logic [NUM_CH*W-1:0] on_ofs_i,
    input logic [NUM_CH*W-1:0] off_ofs_i,
    input logic [NUM_CH-1:0]   en_req_i,
    input logic [NUM_CH-1:0]   pol_i,
    input logic [NUM_CH-1:0]   ch_o,
    input logic [NUM_CH-1:0]   en_lat
);

    assert_enable_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i || frame_end_i) |=> (en_lat == $past(en_req_i)));

    assert_enable_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_i || frame_end_i) |=> (en_lat == $past(en_lat)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_set_on_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (running_i && en_lat[i] && (cnt_i == on_ofs_i[i*W +: W])
             && (cnt_i != off_ofs_i[i*W +: W]))
            |=> (ch_o[i] != $past(pol_i[i])));

        // Also covers R5: equal offsets land here
        assert_clear_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (running_i && en_lat[i] && (cnt_i == off_ofs_i[i*W +: W]))
            |=> (ch_o[i] == $past(pol_i[i])));

        assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !running_i |=> (ch_o[i] == $past(pol_i[i])));

        assert_disabled_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_lat[i] |=> (ch_o[i] == $past(pol_i[i])));
    end

endmodule

bind fpg_bank fpg_bank_chk #(.NUM_CH(NUM_CH), .W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt_i),
    .running_i   (running_i),
    .armed_i     (armed_i),
    .frame_end_i (frame_end_i),
    .on_ofs_i    (on_ofs_i),
    .off_ofs_i   (off_ofs_i),
    .en_req_i    (en_req_i),
    .pol_i       (pol_i),
    .ch_o        (ch_o),
    .en_lat      (en_lat)
);

// File: tb/fpg_bank_tb_top.sv
module fpg_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int W          = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [W-1:0]     cnt;
    logic             running, armed, frame_end;
    logic [NCH*W-1:0] on_v, off_v;
    logic [NCH-1:0]   en_req, pol;
    logic [NCH-1:0]   ch_o;

    logic [NCH-1:0]   exp_en, exp_act, exp_pin;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpg_bank #(.NUM_CH(NCH), .W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .running_i   (running),
        .armed_i     (armed),
        .frame_end_i (frame_end),
        .on_ofs_i    (on_v),
        .off_ofs_i   (off_v),
        .en_req_i    (en_req),
        .pol_i       (pol),
        .ch_o        (ch_o)
    );

    // Next level of one channel from the requirements (R1, R2, R3, R5, R7, R10)
    function automatic logic next_level(logic cur, logic run, logic en,
                                        logic [W-1:0] c, logic [W-1:0] on_o,
                                        logic [W-1:0] off_o);
        if (!run || !en)   return 1'b0;
        if (c == off_o)    return 1'b0;
        if (c == on_o)     return 1'b1;
        return cur;
    endfunction

    task automatic check(string tag, logic [NCH-1:0] got, logic [NCH-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: ch_o=%b expected=%b at cnt=%0d t=%0t", tag, got, exp, cnt, $time);
        end
    endtask

    // Advance one edge with the current inputs, then compare the pins
    task automatic step(string tag);
        if (!rst_n) begin
            exp_en  = '0;
            exp_act = '0;
            exp_pin = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                exp_act[i] = next_level(exp_act[i], running, exp_en[i], cnt,
                                        on_v[i*W +: W], off_v[i*W +: W]);
                exp_pin[i] = exp_act[i] ^ pol[i];
            end
            if (armed || frame_end) exp_en = en_req;
        end
        @(posedge clk);
        #1;
        check(tag, ch_o, exp_pin);
    endtask

    // Run a frame of flen counts, strobing frame_end on the last count
    task automatic run_frame(int flen, string tag);
        running = 1'b1;
        armed   = 1'b0;
        for (int c = 0; c < flen; c++) begin
            cnt       = W'(c);
            frame_end = (c == flen - 1);
            step(tag);
        end
        frame_end = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        rst_n = 1'b0; cnt = '0; running = 1'b0; armed = 1'b0; frame_end = 1'b0;
        on_v = '0; off_v = '0; en_req = '1; pol = 4'b1010;
        exp_en = '0; exp_act = '0; exp_pin = '0;
        #2;
        step("R9 reset clears pins");
        step("R9 reset clears pins");
        rst_n = 1'b1;

        // R8: a distinct shape per channel
        on_v[0*W +: W] = 8'd2; off_v[0*W +: W] = 8'd5;  // plain pulse
        on_v[1*W +: W] = 8'd5; off_v[1*W +: W] = 8'd2;  // wraps the boundary
        on_v[2*W +: W] = 8'd3; off_v[2*W +: W] = 8'd3;  // R5 equal offsets
        on_v[3*W +: W] = 8'd1; off_v[3*W +: W] = 8'd6;  // R6 inverted
        pol = 4'b1000;
        step("R3 idle shows polarity");
        armed = 1'b1; en_req = 4'b1111;
        step("R4 arm latches enables");
        armed = 1'b0;
        run_frame(10, "R1/R2/R5/R6/R8 frame one");
        run_frame(10, "R8/R10 frame two");

        // R4: request drop mid-frame has no effect until frame end
        running = 1'b1;
        for (int c = 0; c < 10; c++) begin
            cnt = W'(c);
            if (c == 3) en_req = 4'b0000;
            frame_end = (c == 9);
            step("R4 mid-frame request ignored");
            if (c == 4) check("R4 channel 0 still active mid-frame", ch_o[0] ? 4'b1 : 4'b0, 4'b1);
        end
        frame_end = 1'b0;
        run_frame(10, "R4/R7 disabled after boundary");

        // R7: enable only channels 0 and 2 at a boundary
        en_req = 4'b0101; cnt = 8'd9; frame_end = 1'b1;
        step("R4 boundary takes request");
        frame_end = 1'b0;
        pol = 4'b0110;
        run_frame(10, "R6/R7 partial enable");

        // R3: stop running while counter sits on set offsets
        running = 1'b0; cnt = 8'd2;
        step("R3 no compare when stopped");
        check("R3 pins equal polarity", ch_o, pol);
        cnt = 8'd1;
        step("R3 no compare when stopped");

        // Random phase
        begin
            int c = 0;
            int flen = 12;
            for (int n = 0; n < 4000; n++) begin
                if ($urandom_range(0, 99) < 5) begin
                    for (int i = 0; i < NCH; i++) begin
                        on_v[i*W +: W]  = W'($urandom_range(0, 15));
                        off_v[i*W +: W] = W'($urandom_range(0, 15));
                    end
                end
                if ($urandom_range(0, 99) < 3)  pol = NCH'($urandom);
                if ($urandom_range(0, 99) < 10) en_req = NCH'($urandom);
                running   = ($urandom_range(0, 99) < 90);
                armed     = ($urandom_range(0, 99) < 2);
                cnt       = W'(c);
                frame_end = (c == flen - 1);
                step("R10 random mix");
                c = (c == flen - 1) ? 0 : c + 1;
            end
        end

        rst_n = 1'b0;
        step("R9 reset clears pins again");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule